// File: doc/BRIEF.md
# Command Mailbox with Background Progress Tracking

This block is the device-side command mailbox of a memory expander. A host reaches it through a plain register port with byte offsets and 64-bit data. To issue a command, the host first writes an opcode and a payload length into the command register. It then sets the doorbell bit in the control register. On the next clock edge the block posts a return code in the status register and drops the doorbell.

Opcodes that take little time finish at once with a success code. Opcodes listed in a parameter are long-running. For these the block posts a "background started" code, sets a busy flag in the status register and hands the work to a stub engine. The engine raises a percent-complete field in the background status register by one step every fixed number of cycles. When the field reaches 100, the busy flag clears and the final return code becomes valid. In the same cycle a one-cycle interrupt fires, provided the interrupt is supported by a parameter and enabled in the control register. A host that leaves the interrupt disabled polls the percent field instead. Payload storage is not modelled, and the payload window reads as zero.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, control, status and background status read 0x0 and `irq` is low.
- R2: The capabilities register at offset 0x00 is read-only and shows `PAYLOAD_EXP` in bits 4:0, `IRQ_SUPPORT` in bit 6 and `IRQ_MSGNUM` in bits 10:7. All other bits read 0.
- R3: A write to control (offset 0x04) with bit 0 set, made while the mailbox is idle, sets the doorbell. Control bit 0 then reads 1 for exactly one cycle, and the doorbell clears on the edge that posts the return code.
- R4: The command register at offset 0x08 holds the opcode in bits 15:0 and the payload length in bits 36:16. An opcode that is not in the background list, with a length of at most 2^`PAYLOAD_EXP` bytes, posts return code 0x0000 in status bits 47:32 and leaves status bit 0 clear.
- R5: A length greater than 2^`PAYLOAD_EXP` posts return code 0x0006 (rejected), even for a background opcode. No background operation starts, and the background status register is unchanged.
- R6: A background opcode with a legal length posts return code 0x0001 and sets status bit 0 (offset 0x10). In the same cycle, background status (offset 0x18) shows the opcode in bits 15:0, percent complete 0 in bits 22:16, return code 0 in bits 47:32 and 0 in bits 63:48.
- R7: Percent complete rises by exactly one every `STEP_CYCLES` cycles. It reaches 100 exactly 100*`STEP_CYCLES` cycles after the return code 0x0001 is posted, and it never exceeds 100.
- R8: Status bit 0 clears in the same cycle that percent complete first reads 100, so the two never read busy and 100 together. The final return code 0x0000 is then valid, and percent complete stays at 100 afterwards.
- R9: With control bit 2 set and `IRQ_SUPPORT` at 1, `irq` is high for exactly one cycle, the cycle in which percent complete first reads 100.
- R10: With control bit 2 clear, `irq` stays low through a complete background operation.
- R11: A doorbell write made while a background operation runs is ignored. The doorbell reads 0, and the return code and percent progress are unaffected. Control bit 2 is still updated by that write.
- R12: Reads of the payload window (offset 0x20 and above) and of other unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| irq | output | 1 | One-cycle background completion interrupt |

## Verification
The embedded assertions assume three things about the host. It writes at most one register per cycle. It writes only mapped offsets with the field layouts above. It does not change `STEP_CYCLES` while the block runs. Under these assumptions, percent complete can only hold or rise by one, a busy flag can never coexist with 100 percent, and the doorbell can never stay up for two cycles. The stimulus keeps within these limits. It drives a single write per task cycle on the falling edge and uses only the documented offsets. It places its one illegal attempt, a doorbell rung during a running operation, where the block must ignore it.

// File: rtl/cmdmb_pkg.sv
// Shared constants for the command mailbox: register offsets, return codes
// and the completion percentage. Assumes byte offsets of eight bits.
package cmdmb_pkg;
    localparam logic [7:0]  OFF_CAPS    = 8'h00;
    localparam logic [7:0]  OFF_CTRL    = 8'h04;
    localparam logic [7:0]  OFF_CMD     = 8'h08;
    localparam logic [7:0]  OFF_STATUS  = 8'h10;
    localparam logic [7:0]  OFF_BGSTAT  = 8'h18;

    localparam logic [15:0] RC_SUCCESS    = 16'h0000;
    localparam logic [15:0] RC_BG_STARTED = 16'h0001;
    localparam logic [15:0] RC_REJECT     = 16'h0006;

    localparam logic [6:0]  PCT_DONE = 7'd100;
endpackage

// File: rtl/cmdmb_opclass.sv
// Opcode classifier: flags an opcode that appears in the parameterised
// background list. Assumes the list is packed with entry 0 in the low bits.
module cmdmb_opclass #(
    parameter int          NUM_BG     = 4,
    parameter logic [NUM_BG*16-1:0] BG_OPCODES = {16'hB203, 16'hB202, 16'hB201, 16'hB200}
) (
    input  logic [15:0] opcode,
    output logic        is_bg
);
    logic [NUM_BG-1:0] hit;

    // One comparator per listed opcode.
    for (genvar i = 0; i < NUM_BG; i++) begin : g_cmp
        assign hit[i] = (opcode == BG_OPCODES[i*16 +: 16]);
    end

    // Any match marks the opcode as long-running.
    assign is_bg = |hit;
endmodule

// File: rtl/cmdmb_bg_engine.sv
// Stub background engine: after start, advances a percent counter by one
// every STEP_CYCLES cycles and finishes at 100 with a success code.
// Assumes start is only pulsed while not busy.
module cmdmb_bg_engine
    import cmdmb_pkg::*;
#(
    parameter int STEP_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] start_opcode,
    output logic        busy,
    output logic [6:0]  pct,
    output logic [15:0] opcode,
    output logic [15:0] final_rc,
    output logic        done
);
    localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STEP_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Progress sequencer: launch, step the percentage, finish at 100.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            pct      <= '0;
            cnt      <= '0;
            opcode   <= '0;
            final_rc <= RC_SUCCESS;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy     <= 1'b1;
                pct      <= '0;
                cnt      <= '0;
                opcode   <= start_opcode;
                final_rc <= RC_SUCCESS;
            end else if (busy) begin
                if (cnt == CNT_LAST) begin
                    cnt <= '0;
                    pct <= pct + 7'd1;
                    if (pct == PCT_DONE - 7'd1) begin
                        busy     <= 1'b0;
                        done     <= 1'b1;
                        final_rc <= RC_SUCCESS;
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // R7: the percentage only holds or rises by one per cycle while running.
    a_r7_pct_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (pct == $past(pct)) || (pct == $past(pct) + 7'd1));

    // R8: busy and a full percentage never coexist.
    a_r8_no_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && pct == PCT_DONE));

    // R7: the percentage never passes 100.
    a_r7_pct_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pct <= PCT_DONE);
endmodule

// File: rtl/cmd_mailbox.sv
// Command mailbox register block. Decodes host register accesses, runs the
// doorbell handshake, posts immediate return codes and hosts the background
// engine. Assumes at most one register write per cycle.
module cmd_mailbox
    import cmdmb_pkg::*;
#(
    parameter int          PAYLOAD_EXP = 8,
    parameter bit          IRQ_SUPPORT = 1'b1,
    parameter int          IRQ_MSGNUM  = 3,
    parameter int          STEP_CYCLES = 16,
    parameter int          NUM_BG      = 4,
    parameter logic [NUM_BG*16-1:0] BG_OPCODES = {16'hB203, 16'hB202, 16'hB201, 16'hB200}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        irq
);
    localparam logic [21:0] PAYLOAD_BYTES = 22'(1) << PAYLOAD_EXP;
    localparam logic [63:0] CAPS_VALUE = {53'd0, 4'(IRQ_MSGNUM), IRQ_SUPPORT, 1'b0, 5'(PAYLOAD_EXP)};

    logic        doorbell, irq_en;
    logic [15:0] cmd_op;
    logic [20:0] cmd_len;
    logic [15:0] last_rc;
    logic        is_bg, len_ok, launch, accept_db;
    logic        bg_busy, bg_done;
    logic [6:0]  bg_pct;
    logic [15:0] bg_op, bg_rc;
    logic [26:0] unused_wdata;

    assign unused_wdata = {reg_wdata[63:37], reg_wdata[1], reg_wdata[31:3] == 29'd0 ? 1'b0 : 1'b1};

    cmdmb_opclass #(.NUM_BG(NUM_BG), .BG_OPCODES(BG_OPCODES)) u_class (
        .opcode (cmd_op),
        .is_bg  (is_bg)
    );

    cmdmb_bg_engine #(.STEP_CYCLES(STEP_CYCLES)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (launch),
        .start_opcode (cmd_op),
        .busy         (bg_busy),
        .pct          (bg_pct),
        .opcode       (bg_op),
        .final_rc     (bg_rc),
        .done         (bg_done)
    );

    // Length check against the advertised payload size.
    assign len_ok = ({1'b0, cmd_len} <= PAYLOAD_BYTES);
    // A background launch happens on the edge that retires the doorbell.
    assign launch = doorbell && len_ok && is_bg;
    // A doorbell is taken only when idle.
    assign accept_db = reg_wr && (reg_addr == OFF_CTRL) && reg_wdata[0] && !doorbell && !bg_busy;

    // Host-writable control and command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en  <= 1'b0;
            cmd_op  <= '0;
            cmd_len <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFF_CTRL) irq_en <= reg_wdata[2];
            if (reg_addr == OFF_CMD) begin
                cmd_op  <= reg_wdata[15:0];
                cmd_len <= reg_wdata[36:16];
            end
        end
    end

    // Doorbell handshake and immediate return-code posting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doorbell <= 1'b0;
            last_rc  <= RC_SUCCESS;
        end else if (doorbell) begin
            doorbell <= 1'b0;
            if (!len_ok)    last_rc <= RC_REJECT;
            else if (is_bg) last_rc <= RC_BG_STARTED;
            else            last_rc <= RC_SUCCESS;
        end else if (accept_db) begin
            doorbell <= 1'b1;
        end
    end

    // Completion interrupt, gated by support and enable.
    assign irq = bg_done && irq_en && IRQ_SUPPORT;

    // Register read mux.
    always_comb begin
        case (reg_addr)
            OFF_CAPS:   reg_rdata = CAPS_VALUE;
            OFF_CTRL:   reg_rdata = {61'd0, irq_en, 1'b0, doorbell};
            OFF_CMD:    reg_rdata = {27'd0, cmd_len, cmd_op};
            OFF_STATUS: reg_rdata = {16'd0, last_rc, 31'd0, bg_busy};
            OFF_BGSTAT: reg_rdata = {16'd0, bg_rc, 9'd0, bg_pct, bg_op};
            default:    reg_rdata = 64'd0;
        endcase
    end

    // R3: the doorbell is up for one cycle only.
    a_r3_doorbell_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);

    // R9: the interrupt is a single-cycle pulse.
    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: the interrupt only fires with the operation finished at 100.
    a_r9_irq_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bg_pct == PCT_DONE) && !bg_busy);

    // R11: no doorbell is taken while a background operation runs.
    a_r11_no_db_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_busy && !doorbell) |=> !doorbell);
endmodule

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;
    localparam int STEP = 3;
    localparam int EXP  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = 64'd0;
    logic [63:0] reg_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    cmd_mailbox #(.PAYLOAD_EXP(EXP), .IRQ_SUPPORT(1'b1), .IRQ_MSGNUM(5),
                  .STEP_CYCLES(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    always #4 clk = ~clk;
    always_ff @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Runs a background operation to completion and checks progress and irq.
    task automatic run_bg(input logic [15:0] op, input bit irq_on, input bit poke_busy);
        logic [63:0] d, s;
        int launch, at100, pulses, irq_cyc, prev;
        bit seen;
        wr(8'h08, {27'd0, 21'd32, op});
        wr(8'h04, irq_on ? 64'h5 : 64'h1);
        rd(8'h04, d);
        chk(d[0] == 1'b1, "R3 doorbell set", d[0], 1);
        @(negedge clk);
        launch = cyc;
        rd(8'h04, d);
        chk(d[0] == 1'b0, "R3 doorbell cleared", d[0], 0);
        rd(8'h10, s);
        chk(s[47:32] == 16'h0001 && s[0], "R6 started code and busy", s, 64'h0000_0001_0000_0001);
        rd(8'h18, d);
        chk(d == {48'd0, op}, "R6 background status at launch", d, {48'd0, op});
        if (poke_busy) begin
            wr(8'h08, {27'd0, 21'd4, 16'h0042});
            wr(8'h04, 64'h5);
            rd(8'h04, d);
            chk(d[0] == 1'b0 && d[2], "R11 doorbell ignored while busy", d, 64'h4);
            @(negedge clk);
            rd(8'h10, s);
            chk(s[47:32] == 16'h0001 && s[0], "R11 status unaffected", s, 64'h0000_0001_0000_0001);
            rd(8'h18, d);
            chk(d[15:0] == op, "R11 background opcode unaffected", d[15:0], op);
        end
        seen = 0; pulses = 0; irq_cyc = -1; at100 = -1; prev = 0;
        for (int k = 0; k < 100 * STEP + 20; k++) begin
            @(negedge clk);
            if (irq) begin pulses++; irq_cyc = cyc; end
            rd(8'h18, d);
            rd(8'h10, s);
            if (d[22:16] > 7'd100 || int'(d[22:16]) < prev)
                chk(0, "R7 percent out of order", d[22:16], prev);
            prev = int'(d[22:16]);
            if (s[0] && d[22:16] == 7'd100)
                chk(0, "R8 busy at 100", s, 0);
            if (!seen && d[22:16] == 7'd100) begin
                seen = 1; at100 = cyc;
                chk(!s[0], "R8 busy clear at 100", s[0], 0);
                chk(d[47:32] == 16'h0000, "R8 final return code", d[47:32], 0);
            end
        end
        chk(seen && (at100 - launch) == 100 * STEP, "R7 completion timing", at100 - launch, 100 * STEP);
        chk(prev == 100, "R8 percent holds at 100", prev, 100);
        if (irq_on) begin
            chk(pulses == 1, "R9 single irq pulse", pulses, 1);
            chk(irq_cyc == at100, "R9 irq aligned with 100", irq_cyc, at100);
        end else begin
            chk(pulses == 0, "R10 no irq when disabled", pulses, 0);
        end
    endtask

    task automatic t_reset;
        logic [63:0] d;
        rd(8'h00, d);
        chk(d == 64'h2C6, "R2 capabilities", d, 64'h2C6);
        rd(8'h04, d);
        chk(d == 0, "R1 control reset", d, 0);
        rd(8'h10, d);
        chk(d == 0, "R1 status reset", d, 0);
        rd(8'h18, d);
        chk(d == 0, "R1 background status reset", d, 0);
        chk(irq == 1'b0, "R1 irq low", irq, 0);
    endtask

    task automatic t_short;
        logic [63:0] d;
        wr(8'h08, {27'd0, 21'd64, 16'h0123});
        rd(8'h08, d);
        chk(d == {27'd0, 21'd64, 16'h0123}, "R4 command readback", d, {27'd0, 21'd64, 16'h0123});
        wr(8'h04, 64'h1);
        rd(8'h04, d);
        chk(d[0], "R3 doorbell up", d[0], 1);
        @(negedge clk);
        rd(8'h04, d);
        chk(!d[0], "R3 doorbell down after one cycle", d[0], 0);
        rd(8'h10, d);
        chk(d == 0, "R4 short command success", d, 0);
    endtask

    task automatic t_reject;
        logic [63:0] d;
        wr(8'h08, {27'd0, 21'd65, 16'hB201});
        wr(8'h04, 64'h1);
        @(negedge clk);
        rd(8'h10, d);
        chk(d == {16'd0, 16'h0006, 32'd0}, "R5 oversize rejected", d, {16'd0, 16'h0006, 32'd0});
        rd(8'h18, d);
        chk(d == 0, "R5 no background launch", d, 0);
    endtask

    task automatic t_window;
        logic [63:0] d;
        for (int a = 8'h20; a < 8'h40; a += 8) begin
            rd(8'(a), d);
            chk(d == 0, "R12 payload window reads zero", d, 0);
        end
        rd(8'h30 + 8'h04, d);
        chk(d == 0, "R12 unmapped reads zero", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_reject();
        run_bg(16'hB200, 1'b1, 1'b1);
        run_bg(16'hB203, 1'b0, 1'b0);
        t_window();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule